// File: doc/BRIEF.md
# Second Pacer with Hourly Drift Trim

This block divides a 32.768 kHz clock enable down to a one-second tick for a real-time clock. It counts qualifying enables in a down-counter and issues a single-cycle tick when the count is used up, then reloads. A nominal second lasts `2**DIV_BITS` enables, which is 32768 with the default parameter.

Crystal drift is corrected once an hour. Software holds a 16-bit two's-complement trim value in two byte-wide registers, which can be written and read one byte at a time. When automatic trimming is enabled and the calendar reports that seconds and minutes are both zero, the second that starts at that reload is made longer or shorter by the trim count. The reload then goes back to nominal. A run control stops the pacer and holds the counter at its nominal reload value. The calendar itself lives outside this block and only supplies the two zero flags.

Top module: `rtc_second_pacer`

## Requirements
- R1: After reset `sec_tick` is low, both trim bytes read back as zero, and the first period once running lasts exactly `2**DIV_BITS` enables.
- R2: A write with `reg_hi_sel`=0 loads `reg_wr_data` into the low byte (trim bits 7:0) and leaves the high byte unchanged. `reg_rd_data` shows the low byte when `reg_rd_hi_sel`=0.
- R3: A write with `reg_hi_sel`=1 loads the high byte (trim bits 15:8, bit 15 being the sign) and leaves the low byte unchanged. `reg_rd_data` shows the high byte when `reg_rd_hi_sel`=1.
- R4: Without a trim, the period from one tick to the next is exactly `2**DIV_BITS` counted enables.
- R5: If a tick is issued while `auto_comp_en`, `sec_is_zero` and `min_is_zero` are all high, the period that starts with it lasts `2**DIV_BITS` plus the signed trim value in enables. Positive values lengthen that second and negative values shorten it.
- R6: A trimmed period never drops below 2 enables. If the signed sum would be lower, the period is 2.
- R7: The trim applies to that one period only. If `auto_comp_en` or either zero flag is low at the reload, the next period is nominal.
- R8: While `run_en` is low, no tick is issued, enables are ignored, and the counter is held at its nominal reload. After `run_en` returns high, the first period is nominal.
- R9: `sec_tick` is high for exactly one cycle. It appears in the cycle after the clock edge that takes the enable ending the period.
- R10: Cycles with `slow_en` low do not advance the count. Periods are measured in enables, not in clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| run_en | input | 1 | Pacer running when high |
| auto_comp_en | input | 1 | Enables the hourly trim |
| sec_is_zero | input | 1 | Calendar seconds field equals zero |
| min_is_zero | input | 1 | Calendar minutes field equals zero |
| reg_wr_en | input | 1 | Trim byte write strobe |
| reg_hi_sel | input | 1 | Write target: 0 low byte, 1 high byte |
| reg_wr_data | input | 8 | Trim byte write data |
| reg_rd_hi_sel | input | 1 | Read select: 0 low byte, 1 high byte |
| reg_rd_data | output | 8 | Selected trim byte |
| sec_tick | output | 1 | One-cycle second tick |

## Verification
A counter that is off by one, or a reload that was picked wrongly, shows up at the very next tick as a period of the wrong length. Counting the enables between ticks therefore exposes the fault within one second. A trim applied with the wrong sign or width, or one that persists, changes the trimmed period or the period after it. A byte write that disturbs the other byte shows up on the readback port in the cycle right after the write. A stop that fails to hold the counter shows up as a tick while stopped, or as a short first period after restart.

// File: rtl/rtc_pacer_pkg.sv
package rtc_pacer_pkg;

    typedef enum logic {
        TRIM_LO = 1'b0,
        TRIM_HI = 1'b1
    } trim_byte_e;

    // counter must hold nominal reload plus the largest positive trim
    function automatic int cnt_width(input int div_bits, input int comp_bits);
        int base;
        base = (div_bits > comp_bits - 1) ? div_bits : comp_bits - 1;
        return base + 2;
    endfunction

endpackage

// File: rtl/rtc_trim_regs.sv
module rtc_trim_regs #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 2,
    localparam int SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1,
    localparam int TRIM_W = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    output logic [TRIM_W-1:0] trim_value
);

    typedef struct packed {
        logic [NBYTES-1:0][BYTE_W-1:0] bytes;
    } trim_state_t;

    trim_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.bytes[wr_sel] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data    = st_q.bytes[rd_sel];
    assign trim_value = st_q.bytes;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte_chk
        // R2 R3: a write loads only its own byte
        a_r2_byte_loaded: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == SEL_W'(b)) |=> st_q.bytes[b] == $past(wr_data));
        a_r3_other_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel != SEL_W'(b)) |=> $stable(st_q.bytes[b]));
    end

endmodule

// File: rtl/rtc_reload_sel.sv
module rtc_reload_sel #(
    parameter int DIV_BITS  = 15,
    parameter int COMP_BITS = 16,
    localparam int CNT_W    = rtc_pacer_pkg::cnt_width(DIV_BITS, COMP_BITS)
) (
    input  logic [COMP_BITS-1:0] trim_value,
    input  logic                 auto_comp_en,
    input  logic                 sec_is_zero,
    input  logic                 min_is_zero,
    output logic [CNT_W-1:0]     reload
);

    localparam logic signed [CNT_W-1:0] NOM_RELOAD = CNT_W'((64'd1 << DIV_BITS) - 64'd1);
    localparam logic signed [CNT_W-1:0] MIN_RELOAD = CNT_W'(1);

    logic                    hour_start;
    logic signed [CNT_W-1:0] trim_ext;
    logic signed [CNT_W-1:0] trimmed;

    assign hour_start = auto_comp_en && sec_is_zero && min_is_zero;

    always_comb begin
        trim_ext = {{(CNT_W-COMP_BITS){trim_value[COMP_BITS-1]}}, trim_value};
        trimmed  = NOM_RELOAD + trim_ext;
        if (!hour_start) begin
            reload = NOM_RELOAD;
        end else if (trimmed < MIN_RELOAD) begin
            reload = MIN_RELOAD;
        end else begin
            reload = trimmed;
        end
    end

endmodule

// File: rtl/rtc_divider.sv
module rtc_divider #(
    parameter int DIV_BITS = 15,
    parameter int CNT_W    = 17,
    localparam logic [CNT_W-1:0] NOM_RELOAD = CNT_W'((64'd1 << DIV_BITS) - 64'd1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_en,
    input  logic             run_en,
    input  logic [CNT_W-1:0] reload,
    output logic             tick
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (!run_en) begin
            st_d.cnt = NOM_RELOAD;
        end else if (slow_en) begin
            if (st_q.cnt == '0) begin
                st_d.cnt  = reload;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= NOM_RELOAD;
            st_q.tick <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;

    // R8: stopped pacer never ticks and sits at nominal reload
    a_r8_no_tick_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !tick);
    a_r8_hold_nominal: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> st_q.cnt == NOM_RELOAD);
    // R9: tick lasts one cycle (reload is at least 1)
    a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    // R10: idle cycles leave the count untouched
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !slow_en) |=> $stable(st_q.cnt));
    // R4: each enable steps the count down by one
    a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && slow_en && st_q.cnt != '0) |=> st_q.cnt == $past(st_q.cnt) - 1'b1);
    // R6: reload handed to the counter never drops below 1
    a_r6_reload_floor: assert property (@(posedge clk) disable iff (!rst_n)
        reload != '0);

endmodule

// File: rtl/rtc_second_pacer.sv
module rtc_second_pacer #(
    parameter int DIV_BITS = 15,
    parameter int BYTE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_en,
    input  logic              run_en,
    input  logic              auto_comp_en,
    input  logic              sec_is_zero,
    input  logic              min_is_zero,
    input  logic              reg_wr_en,
    input  logic              reg_hi_sel,
    input  logic [BYTE_W-1:0] reg_wr_data,
    input  logic              reg_rd_hi_sel,
    output logic [BYTE_W-1:0] reg_rd_data,
    output logic              sec_tick
);

    localparam int COMP_BITS = 2 * BYTE_W;
    localparam int CNT_W     = rtc_pacer_pkg::cnt_width(DIV_BITS, COMP_BITS);

    logic [COMP_BITS-1:0] trim_value;
    logic [CNT_W-1:0]     reload;

    rtc_trim_regs #(
        .BYTE_W (BYTE_W),
        .NBYTES (2)
    ) u_trim_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .wr_sel     (reg_hi_sel),
        .wr_data    (reg_wr_data),
        .rd_sel     (reg_rd_hi_sel),
        .rd_data    (reg_rd_data),
        .trim_value (trim_value)
    );

    rtc_reload_sel #(
        .DIV_BITS  (DIV_BITS),
        .COMP_BITS (COMP_BITS)
    ) u_reload_sel (
        .trim_value   (trim_value),
        .auto_comp_en (auto_comp_en),
        .sec_is_zero  (sec_is_zero),
        .min_is_zero  (min_is_zero),
        .reload       (reload)
    );

    rtc_divider #(
        .DIV_BITS (DIV_BITS),
        .CNT_W    (CNT_W)
    ) u_divider (
        .clk     (clk),
        .rst_n   (rst_n),
        .slow_en (slow_en),
        .run_en  (run_en),
        .reload  (reload),
        .tick    (sec_tick)
    );

    // R7: without the hour condition the reload is nominal
    a_r7_nominal_off_hour: assert property (@(posedge clk) disable iff (!rst_n)
        !(auto_comp_en && sec_is_zero && min_is_zero) |-> reload == CNT_W'((64'd1 << DIV_BITS) - 64'd1));

endmodule

// File: tb/rtc_second_pacer_bench.sv
module rtc_second_pacer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DIVB       = 6;
    localparam int NOM        = 1 << DIVB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_en = 1'b0, run_en = 1'b0, auto_comp_en = 1'b0;
    logic       sec_is_zero = 1'b0, min_is_zero = 1'b0;
    logic       reg_wr_en = 1'b0, reg_hi_sel = 1'b0, reg_rd_hi_sel = 1'b0;
    logic [7:0] reg_wr_data = 8'h00;
    logic [7:0] reg_rd_data;
    logic       sec_tick;

    int checks = 0;
    int fails  = 0;
    int en_count = 0;
    int exp_period = NOM;
    string exp_tag = "R1";
    logic [15:0] reg_m = '0, reg_prev = '0;
    bit run_prev = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_second_pacer #(.DIV_BITS(DIVB), .BYTE_W(8)) u_rtc_second_pacer (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .run_en(run_en),
        .auto_comp_en(auto_comp_en), .sec_is_zero(sec_is_zero), .min_is_zero(min_is_zero),
        .reg_wr_en(reg_wr_en), .reg_hi_sel(reg_hi_sel), .reg_wr_data(reg_wr_data),
        .reg_rd_hi_sel(reg_rd_hi_sel), .reg_rd_data(reg_rd_data), .sec_tick(sec_tick)
    );

    function automatic int next_period(bit au, bit s0, bit m0, logic [15:0] trim);
        int p;
        if (!(au && s0 && m0)) return NOM;
        p = NOM + int'($signed(trim));
        if (p < 2) p = 2;
        return p;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one clock: observe result of the last edge, then drive the next inputs
    task automatic cycle(bit en, bit run, bit au, bit s0, bit m0,
                         bit wr, bit hi, logic [7:0] wd, bit rhi);
        @(negedge clk);
        reg_prev = reg_m;
        if (reg_wr_en) begin
            if (reg_hi_sel) reg_m[15:8] = reg_wr_data;
            else            reg_m[7:0]  = reg_wr_data;
        end
        if (sec_tick) begin
            if (!run_prev) begin
                check(1'b0, "R8 tick while stopped", 1, 0);
            end else begin
                check(en_count == exp_period, exp_tag, en_count, exp_period);
            end
            en_count   = 0;
            exp_period = next_period(auto_comp_en, sec_is_zero, min_is_zero, reg_prev);
            if (exp_period == NOM)      exp_tag = "R4 R7 R10 period";
            else if (exp_period == 2 && NOM + int'($signed(reg_prev)) < 2)
                                        exp_tag = "R6 clamped period";
            else                        exp_tag = "R5 trimmed period";
        end else if (run_prev && en_count >= exp_period) begin
            check(1'b0, {exp_tag, " missing tick"}, en_count, exp_period);
            en_count = 0;
        end
        run_prev = run_en;
        if (!run_en) begin
            en_count   = 0;
            exp_period = NOM;
            exp_tag    = "R8 restart period";
        end
        slow_en = en; run_en = run; auto_comp_en = au;
        sec_is_zero = s0; min_is_zero = m0;
        reg_wr_en = wr; reg_hi_sel = hi; reg_wr_data = wd; reg_rd_hi_sel = rhi;
        if (en && run) en_count++;
        #1;
        if (rhi) check(reg_rd_data == reg_m[15:8], "R3 high byte readback", reg_rd_data, reg_m[15:8]);
        else     check(reg_rd_data == reg_m[7:0],  "R2 low byte readback",  reg_rd_data, reg_m[7:0]);
    endtask

    task automatic set_trim(logic [15:0] v);
        cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, v[7:0], 1'b1);
        cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, v[15:8], 1'b0);
        cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    endtask

    task automatic run_steady(int n, bit au, bit s0, bit m0);
        for (int i = 0; i < n; i++) begin
            cycle(1'b1, 1'b1, au, s0, m0, 1'b0, 1'b0, 8'h00, i[0]);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        check(sec_tick == 1'b0, "R1 tick low in reset", sec_tick, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(reg_rd_data == 8'h00, "R1 low byte after reset", reg_rd_data, 0);
        reg_rd_hi_sel = 1'b1;
        #1;
        check(reg_rd_data == 8'h00, "R1 high byte after reset", reg_rd_data, 0);

        // R1 R4: first periods nominal
        run_steady(3 * NOM + 5, 1'b0, 1'b1, 1'b1);

        // R2 R3: byte independence
        cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h5A, 1'b0);
        cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hC3, 1'b0);
        cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
        cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h11, 1'b1);
        cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);

        // R5: positive and negative trims at the top of the hour
        set_trim(16'd10);
        run_steady(5 * NOM, 1'b1, 1'b1, 1'b1);
        set_trim(-16'sd20);
        run_steady(5 * NOM, 1'b1, 1'b1, 1'b1);
        set_trim(16'd200);
        run_steady(3 * NOM + 600, 1'b1, 1'b1, 1'b1);
        // R6: floor at two enables
        set_trim(-16'sd100);
        run_steady(40, 1'b1, 1'b1, 1'b1);
        set_trim(-16'sd62);
        run_steady(40, 1'b1, 1'b1, 1'b1);
        set_trim(-16'sd61);
        run_steady(40, 1'b1, 1'b1, 1'b1);
        set_trim(16'h8000);
        run_steady(40, 1'b1, 1'b1, 1'b1);
        // R7: any missing condition gives a nominal period
        set_trim(16'd30);
        run_steady(4 * NOM, 1'b0, 1'b1, 1'b1);
        run_steady(4 * NOM, 1'b1, 1'b0, 1'b1);
        run_steady(4 * NOM, 1'b1, 1'b1, 1'b0);
        // R8: enables while stopped are ignored, restart is nominal
        run_steady(NOM / 2, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 50; i++) cycle(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
        run_steady(3 * NOM, 1'b0, 1'b0, 1'b0);

        // random mix: R4 R5 R6 R7 R8 R9 R10
        for (int i = 0; i < 60000; i++) begin
            bit en, run, au, s0, m0, wr, hi, rhi;
            logic [7:0] wd;
            en  = ($urandom % 4) != 0;
            run = ($urandom % 500) != 0 || (i % 1000 > 20);
            au  = ($urandom % 4) != 0;
            s0  = ($urandom % 2) != 0;
            m0  = ($urandom % 3) != 0;
            wr  = ($urandom % 300) == 0;
            hi  = $urandom % 2;
            wd  = hi ? (($urandom % 2) ? 8'hFF : 8'h00) : 8'($urandom);
            rhi = $urandom % 2;
            cycle(en, run, au, s0, m0, wr, hi, wd, rhi);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule